// File: doc/BRIEF.md
# Fixed-Point Passive Neuron Integrator

This block advances one passive model neuron by one forward-Euler step of 0.1 ms each time `step_i` is high at a clock edge. It keeps four registers: the membrane voltage, a fast synaptic trace (1.5 ms time constant), a slow synaptic trace (5 ms), and a count of completed steps. The trace difference (slow minus fast) sets a synaptic conductance of 300 pS per unit. The voltage moves under three currents: a 2 nS leak toward -64 mV, a 30 pA injected pulse gated by the step count, and that synaptic current toward 0 mV. The membrane capacitance is 10 pF. Each current is folded into a per-step voltage increment computed in scaled integer arithmetic. The widened sums saturate instead of wrapping. A pulse on `syn_event_i` adds one unit to both traces.

The voltage leaves on `v_o`, qualified by `v_valid_o`. The output behaves as a one-cycle strobe stream. It has no ready signal and no back-pressure, so a consumer must capture `v_o` in the cycle `v_valid_o` is high. `v_o` then holds until the next step. `step_i` and `syn_event_i` are plain control inputs, sampled at every rising edge.

Top module: `neuron_integrator`

## Requirements
- R1: Synchronous active-high `rst` sets `v_o` to -1099511628, which is -64 mV in units of 2^-34 V. It also sets `v_valid_o` low and sets both traces and the step count to zero.
- R2: `v_o` is a signed 32-bit value with an LSB of 2^-34 V (full scale ±0.125 V). In a cycle with `step_i` low, `v_o` keeps its value and `v_valid_o` is low.
- R3: When `step_i` is high at an edge, `v_valid_o` is high for exactly the following cycle, and `v_o` carries the new voltage in that same cycle.
- R4: The leak increment is ((-1099511628 - V) * 1311) >>> 16. It uses an arithmetic (floor) shift, and V is the voltage before the step.
- R5: The injection increment is 5153961 when 500 < t < 1000, and 0 otherwise. Here t is the number of steps completed before this step. t counts up by one on each step and saturates at its maximum.
- R6: Traces are unsigned 32-bit, with one unit equal to 65536. On a step, the fast trace F becomes F - ((F*4369) >> 16), and the slow trace S becomes S - ((S*1311) >> 16).
- R7: The synaptic increment is ((-V) * (S - F) * 197) >>> 32. It uses V, S and F from before the step.
- R8: With `syn_event_i` high and `step_i` low, both traces gain 65536, saturating at 2^32-1.
- R9: With `syn_event_i` and `step_i` both high, the 65536 bump is applied to the already-decayed traces, and the voltage of that step uses the traces from before the decay.
- R10: The new voltage is V plus the leak, injection and synaptic increments, computed wide and saturated to the range -2^31 to 2^31-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | Advance the neuron by one 0.1 ms step |
| syn_event_i | input | 1 | Synaptic event: bump both traces by one unit |
| v_o | output | 32 | Membrane voltage, signed, LSB 2^-34 V |
| v_valid_o | output | 1 | One-cycle strobe marking a freshly stepped voltage |

## Verification
The assertions assume that `step_i` and `syn_event_i` are sampled one edge at a time, so a level held for N cycles means N steps or N events. They also assume reset is released synchronously. The stimulus changes inputs only just after an edge. It mixes isolated steps, idle gaps, lone events and events that coincide with steps. It runs the step count across both edges of the injection window. A second phase sends more events than the trace width can hold, so the trace registers saturate; the following steps then drive the voltage into its saturation limits.

// File: rtl/neuron_fx_pkg.sv
package neuron_fx_pkg;
  localparam int V_W    = 32;
  localparam int G_W    = 32;
  localparam int FRAC_W = 16;
  localparam int ACC_W  = V_W + G_W + FRAC_W;

  typedef logic signed [V_W-1:0]   volt_t;
  typedef logic        [G_W-1:0]   gate_t;
  typedef logic signed [ACC_W-1:0] acc_t;

  function automatic volt_t sat_volt(input acc_t x);
    acc_t hi;
    acc_t lo;
    hi = {{(ACC_W-V_W+1){1'b0}}, {(V_W-1){1'b1}}};
    lo = ~hi;
    if (x > hi)      return {1'b0, {(V_W-1){1'b1}}};
    else if (x < lo) return {1'b1, {(V_W-1){1'b0}}};
    else             return x[V_W-1:0];
  endfunction
endpackage

// File: rtl/gate_trace.sv
module gate_trace
  import neuron_fx_pkg::*;
#(
  parameter int K_DECAY = 1311,
  parameter int EV_INC  = 65536
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  step_i,
  input  logic  ev_i,
  output gate_t level_o
);
  localparam int PROD_W = G_W + FRAC_W;

  logic [PROD_W-1:0] prod;
  gate_t             loss;
  gate_t             decayed;
  gate_t             base;
  logic [G_W:0]      bumped;
  gate_t             nxt;

  always_comb begin
    prod    = {{FRAC_W{1'b0}}, level_o} * PROD_W'(K_DECAY);
    loss    = prod[PROD_W-1:FRAC_W];
    decayed = level_o - loss;
    base    = step_i ? decayed : level_o;
    bumped  = {1'b0, base} + (G_W+1)'(EV_INC);
    if (!ev_i)           nxt = base;
    else if (bumped[G_W]) nxt = '1;
    else                 nxt = bumped[G_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) level_o <= '0;
    else     level_o <= nxt;
  end

  // R6: a step without an event never raises the trace
  assert_decay_no_rise_R6: assert property (@(posedge clk) disable iff (rst)
    (step_i && !ev_i) |=> (level_o <= $past(level_o)));

  // R8: a lone event adds one unit when there is headroom
  assert_event_bump_R8: assert property (@(posedge clk) disable iff (rst)
    (ev_i && !step_i && (({1'b0, level_o} + (G_W+1)'(EV_INC)) <= {1'b0, {G_W{1'b1}}}))
    |=> (level_o == $past(level_o) + G_W'(EV_INC)));

  // R8: a saturated trace stays saturated under a lone event
  assert_event_sat_R8: assert property (@(posedge clk) disable iff (rst)
    (ev_i && !step_i && (level_o == '1)) |=> (level_o == '1));
endmodule

// File: rtl/stim_window.sv
module stim_window
  import neuron_fx_pkg::*;
#(
  parameter int TIME_W = 32,
  parameter int T_ON   = 500,
  parameter int T_OFF  = 1000,
  parameter int I_INJ  = 5153961
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  step_i,
  output volt_t inj_o
);
  logic [TIME_W-1:0] tick;
  logic              in_win;

  always_comb begin
    in_win = (tick > TIME_W'(T_ON)) && (tick < TIME_W'(T_OFF));
    inj_o  = in_win ? volt_t'(I_INJ) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst)                        tick <= '0;
    else if (step_i && tick != '1)  tick <= tick + 1'b1;
  end

  // R5: the step count advances by one per step until it saturates
  assert_count_advance_R5: assert property (@(posedge clk) disable iff (rst)
    (step_i && tick != '1) |=> (tick == $past(tick) + 1'b1));

  // R5: the step count holds without a step
  assert_count_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> $stable(tick));
endmodule

// File: rtl/membrane_update.sv
module membrane_update
  import neuron_fx_pkg::*;
#(
  parameter int V_REST = -1099511628,
  parameter int K_LEAK = 1311,
  parameter int K_SYN  = 197
) (
  input  volt_t v_i,
  input  gate_t fast_i,
  input  gate_t slow_i,
  input  volt_t inj_i,
  output volt_t v_next_o
);
  acc_t v_w;
  acc_t diff;
  acc_t leak;
  acc_t g;
  acc_t syn_prod;
  acc_t syn;
  acc_t total;

  always_comb begin
    v_w      = acc_t'(v_i);
    diff     = acc_t'(V_REST) - v_w;
    leak     = (diff * acc_t'(K_LEAK)) >>> FRAC_W;
    g        = acc_t'({1'b0, slow_i}) - acc_t'({1'b0, fast_i});
    syn_prod = (-v_w) * g * acc_t'(K_SYN);
    syn      = syn_prod >>> (2*FRAC_W);
    total    = v_w + leak + acc_t'(inj_i) + syn;
    v_next_o = sat_volt(total);
  end
endmodule

// File: rtl/neuron_integrator.sv
module neuron_integrator
  import neuron_fx_pkg::*;
#(
  parameter int TIME_W       = 32,
  parameter int T_ON         = 500,
  parameter int T_OFF        = 1000,
  parameter int I_INJ        = 5153961,
  parameter int V_REST       = -1099511628,
  parameter int K_LEAK       = 1311,
  parameter int K_SYN        = 197,
  parameter int K_DECAY_FAST = 4369,
  parameter int K_DECAY_SLOW = 1311,
  parameter int EV_INC       = 65536
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_i,
  input  logic              syn_event_i,
  output logic signed [31:0] v_o,
  output logic              v_valid_o
);
  localparam int N_TRACE = 2;

  gate_t lvl [N_TRACE];
  volt_t inj;
  volt_t v_next;

  stim_window #(
    .TIME_W(TIME_W), .T_ON(T_ON), .T_OFF(T_OFF), .I_INJ(I_INJ)
  ) u_window (
    .clk(clk), .rst(rst), .step_i(step_i), .inj_o(inj)
  );

  for (genvar i = 0; i < N_TRACE; i++) begin : g_trace
    gate_trace #(
      .K_DECAY((i == 0) ? K_DECAY_FAST : K_DECAY_SLOW),
      .EV_INC (EV_INC)
    ) u_trace (
      .clk(clk), .rst(rst), .step_i(step_i), .ev_i(syn_event_i),
      .level_o(lvl[i])
    );
  end

  membrane_update #(
    .V_REST(V_REST), .K_LEAK(K_LEAK), .K_SYN(K_SYN)
  ) u_update (
    .v_i(v_o), .fast_i(lvl[0]), .slow_i(lvl[1]), .inj_i(inj),
    .v_next_o(v_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      v_o       <= volt_t'(V_REST);
      v_valid_o <= 1'b0;
    end else begin
      v_valid_o <= step_i;
      if (step_i) v_o <= v_next;
    end
  end

  // R3: each step produces a strobe in the next cycle
  assert_step_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    step_i |=> v_valid_o);

  // R2: no step, no strobe, voltage held
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> (!v_valid_o && $stable(v_o)));
endmodule

// File: tb/neuron_integrator_tb.sv
module neuron_integrator_tb;
  localparam longint VREST = -64'sd1099511628;
  localparam longint GMAX  = 64'sd4294967295;
  localparam longint VHI   = 64'sd2147483647;
  localparam longint VLO   = -64'sd2147483648;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic step_i = 1'b0;
  logic syn_event_i = 1'b0;
  logic signed [31:0] v_o;
  logic v_valid_o;

  neuron_integrator u_dut (
    .clk(clk), .rst(rst), .step_i(step_i), .syn_event_i(syn_event_i),
    .v_o(v_o), .v_valid_o(v_valid_o)
  );

  always #5 clk = ~clk;

  int    n_cmp  = 0;
  int    n_bad  = 0;
  bit    live   = 1'b0;
  bit    done   = 1'b0;
  string tag    = "R1";

  longint mv = VREST, mf = 0, ms = 0, mt = 0;
  bit     mvalid = 1'b0;
  longint nf, ns, leak, inj, syn, tot;
  logic signed [95:0] wide;

  // behavioural reference, advanced on each edge
  always @(posedge clk) begin
    live = 1'b1;
    if (rst) begin
      mv = VREST; mf = 0; ms = 0; mt = 0; mvalid = 1'b0;
    end else begin
      mvalid = step_i;
      nf = mf; ns = ms;
      if (step_i) begin
        nf   = mf - ((mf * 4369) >>> 16);
        ns   = ms - ((ms * 1311) >>> 16);
        leak = ((VREST - mv) * 1311) >>> 16;
        inj  = (mt > 500 && mt < 1000) ? 64'sd5153961 : 64'sd0;
        wide = 96'(-mv) * 96'(ms - mf) * 96'sd197;
        syn  = longint'(wide >>> 32);
        tot  = mv + leak + inj + syn;
        mv   = (tot > VHI) ? VHI : (tot < VLO) ? VLO : tot;
        if (mt < GMAX) mt = mt + 1;
      end
      if (syn_event_i) begin
        nf = (nf + 65536 > GMAX) ? GMAX : nf + 65536;
        ns = (ns + 65536 > GMAX) ? GMAX : ns + 65536;
      end
      mf = nf; ms = ns;
    end
  end

  always @(negedge clk) begin
    if (live && !done) begin
      n_cmp++;
      if (longint'(v_o) != mv || v_valid_o != mvalid) begin
        n_bad++;
        $display("FAIL %s t=%0t actual v=%0d valid=%0b expected v=%0d valid=%0b",
                 tag, $time, v_o, v_valid_o, mv, mvalid);
      end
    end
  end

  task automatic cyc(input logic s, input logic e);
    step_i = s;
    syn_event_i = e;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_bad++;
      $display("FAIL R3 watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    tag = "R1";
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    repeat (2) cyc(0, 0);

    tag = "R2";
    repeat (10) cyc(0, 0);

    tag = "R3/R4";
    for (int i = 0; i < 20; i++) begin cyc(1, 0); cyc(0, 0); end

    tag = "R6/R7/R8";
    repeat (3) cyc(0, 1);
    for (int i = 0; i < 60; i++) cyc(1, 0);
    cyc(0, 1);
    for (int i = 0; i < 30; i++) begin cyc(1, 0); cyc(0, 0); end

    tag = "R9";
    repeat (10) cyc(1, 1);
    repeat (40) cyc(1, 0);

    tag = "R5";
    for (int i = 0; i < 1100; i++) cyc(1, (i % 250) == 0);

    tag = "R1";
    rst = 1'b1;
    repeat (2) cyc(0, 0);
    rst = 1'b0;
    cyc(0, 0);

    tag = "R8/R10";
    for (int i = 0; i < 70000; i++) cyc(0, 1);
    for (int i = 0; i < 300; i++) cyc(1, 0);

    cyc(0, 0);
    finish_run();
  end
endmodule